// File: doc/BRIEF.md
# Four-Channel Counted Excitation Pulse Generator

This block drives four excitation outputs from one pulse engine that runs on the converter clock. Software programs a configuration word and a control word. The configuration word holds a pulse count, a speed select and two free-run switches. The control word holds a per-output enable and a per-output polarity flip. A one-cycle start strobe then launches a train of pulses. Each pulse occupies one cycle of a phase counter. That cycle is 16 clocks long at normal speed and 8 clocks long at double speed. The output is high during the first half of each cycle.

In counted mode the engine stops after the programmed number of cycles. In pulse free-run mode it repeats cycles for as long as at least one output is enabled. The phase counter can also free-run while the engine is idle, provided the converter-enable input is high. A busy status reports whether the engine is running. Both words read back on their own ports, and the busy flag is appended to the control word.

Top module: `excite_pulse_gen`

## Requirements
- R1: After reset, both readback words are zero, busy is 0, phase is 0, and every output is 0.
- R2: A configuration write stores count in bits [11:0], the double-speed select in bit 12, phase free-run in bit 13 and pulse free-run in bit 14. A control write stores the invert flags in bits [3:0] and the enables in bits [7:4], output i using bit i and bit 4+i. Busy reads back at control readback bit 8. A write takes effect on the next clock edge.
- R3: With pulse free-run off and count N>0, a start seen while idle raises busy on the next edge. Busy then stays high for exactly N full cycles, which is N×16 clocks at normal speed.
- R4: A cycle lasts 16 clocks when bit 12 is 0 and 8 clocks when it is 1. The pulse is high for the first 8 (or 4) clocks of each cycle.
- R5: With pulse free-run off and count 0, a start has no effect and busy stays 0.
- R6: With pulse free-run on, a start with at least one enable set runs the engine without limit, whatever the count. If all four enables are 0, busy falls on the following edge. A start with no enables set has no effect.
- R7: While busy, the phase counter advances by one each clock and wraps to 0 after the last phase of the cycle. While idle, it advances the same way only when phase free-run is on and adc_en is high; otherwise it is 0.
- R8: Output i equals (enable i AND busy AND pulse-high) XOR invert i. A disabled output therefore rests at its invert bit.
- R9: A start that arrives while busy is ignored and does not extend the train.
- R10: Busy falls on the edge that completes the last cycle, and phase is 0 on that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| adc_en | input | 1 | Converter enable; lets the phase counter free-run while idle |
| cfg_we | input | 1 | Configuration word write strobe |
| cfg_wdata | input | 15 | Configuration word: count, speed, phase free-run, pulse free-run |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 8 | Control word: invert flags [3:0], enables [7:4] |
| start | input | 1 | One-cycle start strobe |
| cfg_rdata | output | 15 | Configuration word readback |
| ctl_rdata | output | 9 | Control word readback with busy in bit 8 |
| busy | output | 1 | Engine running |
| phase | output | 4 | Current phase counter value |
| exc_out | output | 4 | Excitation outputs |

## Verification
A wrong remaining-pulse count moves the falling edge of busy by a whole cycle of 8 or 16 clocks. A wrong phase value changes the phase port and the outputs in the very next clock. A wrong cycle-end or half-cycle decision moves an output edge by at least one clock. The bench keeps a behavioural model and compares every output port against it on each clock. Most state faults are therefore caught within one cycle. A count fault is caught no later than the clock where busy should have fallen.

// File: rtl/epg_pkg.sv
package epg_pkg;
    localparam int CNT_W  = 12;
    localparam int N_OUT  = 4;
    localparam int PH_W   = 4;
    localparam int CFG_W  = CNT_W + 3;
    localparam int CTL_W  = 2 * N_OUT;

    typedef struct packed {
        logic             active;
        logic [CNT_W-1:0] rem;
        logic [PH_W-1:0]  phase;
    } eng_t;

    typedef struct packed {
        logic [CFG_W-1:0] cfg;
        logic [CTL_W-1:0] ctl;
    } regs_t;
endpackage

// File: rtl/epg_regs.sv
module epg_regs
    import epg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             ctl_we,
    input  logic [CTL_W-1:0] ctl_wdata,
    output logic [CFG_W-1:0] cfg_q,
    output logic [CTL_W-1:0] ctl_q
);
    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (cfg_we) r_d.cfg = cfg_wdata;
        if (ctl_we) r_d.ctl = ctl_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign cfg_q = r_q.cfg;
    assign ctl_q = r_q.ctl;
endmodule

// File: rtl/epg_engine.sv
module epg_engine
    import epg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             adc_en,
    input  logic [CNT_W-1:0] count,
    input  logic             fast,
    input  logic             phase_free,
    input  logic             pulse_free,
    input  logic             any_en,
    output logic             busy,
    output logic [PH_W-1:0]  phase,
    output logic             pulse_hi
);
    localparam int SLOW_LEN = 2 ** PH_W;
    localparam int FAST_LEN = SLOW_LEN / 2;
    localparam logic [PH_W-1:0] SLOW_LAST = PH_W'(SLOW_LEN - 1);
    localparam logic [PH_W-1:0] FAST_LAST = PH_W'(FAST_LEN - 1);
    localparam logic [PH_W-1:0] SLOW_HALF = PH_W'(SLOW_LEN / 2);
    localparam logic [PH_W-1:0] FAST_HALF = PH_W'(FAST_LEN / 2);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    eng_t e_d, e_q;
    logic            last;
    logic [PH_W-1:0] ph_next;
    logic            launch;

    always_comb begin
        last    = e_q.phase >= (fast ? FAST_LAST : SLOW_LAST);
        ph_next = last ? '0 : e_q.phase + 1'b1;
        launch  = start && (pulse_free ? any_en : (count != '0));
        e_d     = e_q;
        if (!e_q.active) begin
            if (launch) begin
                e_d.active = 1'b1;
                e_d.rem    = count;
                e_d.phase  = '0;
            end else if (phase_free && adc_en) begin
                e_d.phase = ph_next;
            end else begin
                e_d.phase = '0;
            end
        end else if (pulse_free && !any_en) begin
            e_d.active = 1'b0;
            e_d.phase  = '0;
        end else if (last) begin
            e_d.phase = '0;
            if (!pulse_free) begin
                if (e_q.rem <= ONE) e_d.active = 1'b0;
                else                e_d.rem    = e_q.rem - ONE;
            end
        end else begin
            e_d.phase = ph_next;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) e_q <= '0;
        else        e_q <= e_d;
    end

    assign busy     = e_q.active;
    assign phase    = e_q.phase;
    assign pulse_hi = e_q.active && (e_q.phase < (fast ? FAST_HALF : SLOW_HALF));
endmodule

// File: rtl/epg_outs.sv
module epg_outs
    import epg_pkg::*;
(
    input  logic             pulse_hi,
    input  logic [N_OUT-1:0] en,
    input  logic [N_OUT-1:0] inv,
    output logic [N_OUT-1:0] exc
);
    for (genvar i = 0; i < N_OUT; i++) begin : g_ch
        assign exc[i] = (en[i] & pulse_hi) ^ inv[i];
    end
endmodule

// File: rtl/excite_pulse_gen.sv
module excite_pulse_gen
    import epg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adc_en,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             ctl_we,
    input  logic [CTL_W-1:0] ctl_wdata,
    input  logic             start,
    output logic [CFG_W-1:0] cfg_rdata,
    output logic [CTL_W:0]   ctl_rdata,
    output logic             busy,
    output logic [PH_W-1:0]  phase,
    output logic [N_OUT-1:0] exc_out
);
    logic [CFG_W-1:0] cfg_q;
    logic [CTL_W-1:0] ctl_q;
    logic [CNT_W-1:0] cfg_count;
    logic             cfg_fast, cfg_phase_free, cfg_pulse_free;
    logic [N_OUT-1:0] out_en, out_inv;
    logic             pulse_hi;

    assign cfg_count      = cfg_q[CNT_W-1:0];
    assign cfg_fast       = cfg_q[CNT_W];
    assign cfg_phase_free = cfg_q[CNT_W+1];
    assign cfg_pulse_free = cfg_q[CNT_W+2];
    assign out_inv        = ctl_q[N_OUT-1:0];
    assign out_en         = ctl_q[CTL_W-1:N_OUT];

    epg_regs regs_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .cfg_q(cfg_q), .ctl_q(ctl_q)
    );

    epg_engine eng_i (
        .clk(clk), .rst_n(rst_n), .start(start), .adc_en(adc_en),
        .count(cfg_count), .fast(cfg_fast),
        .phase_free(cfg_phase_free), .pulse_free(cfg_pulse_free),
        .any_en(|out_en),
        .busy(busy), .phase(phase), .pulse_hi(pulse_hi)
    );

    epg_outs outs_i (
        .pulse_hi(pulse_hi), .en(out_en), .inv(out_inv), .exc(exc_out)
    );

    assign cfg_rdata = cfg_q;
    assign ctl_rdata = {busy, ctl_q};
endmodule

// File: rtl/epg_checker.sv
module epg_checker
    import epg_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             busy,
    input logic [PH_W-1:0]  phase,
    input logic [N_OUT-1:0] exc_out,
    input logic [CNT_W-1:0] cnt,
    input logic             pfree,
    input logic [N_OUT-1:0] en,
    input logic [N_OUT-1:0] inv
);
    a_r3_rise_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    a_r5_zero_count_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && !pfree && cnt == '0) |=> !busy);

    a_r6_no_enable_stops: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && pfree && en == '0) |=> !busy);

    a_r7_phase_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && phase != '0) |-> (phase == $past(phase) + 1'b1));

    a_r8_disabled_rest: assert property (@(posedge clk) disable iff (!rst_n)
        ((exc_out ^ inv) & ~en) == '0);

    a_r10_stop_phase_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (phase == '0));
endmodule

bind excite_pulse_gen epg_checker chk_i (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .phase(phase),
    .exc_out(exc_out), .cnt(cfg_count), .pfree(cfg_pulse_free),
    .en(out_en), .inv(out_inv)
);

// File: tb/excite_pulse_gen_tb_top.sv
module excite_pulse_gen_tb_top;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        adc_en = 0;
    logic        cfg_we = 0;
    logic [14:0] cfg_wdata = '0;
    logic        ctl_we = 0;
    logic [7:0]  ctl_wdata = '0;
    logic        start = 0;
    logic [14:0] cfg_rdata;
    logic [8:0]  ctl_rdata;
    logic        busy;
    logic [3:0]  phase;
    logic [3:0]  exc_out;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #10 clk = ~clk;

    excite_pulse_gen dut_i (
        .clk(clk), .rst_n(rst_n), .adc_en(adc_en),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .start(start), .cfg_rdata(cfg_rdata), .ctl_rdata(ctl_rdata),
        .busy(busy), .phase(phase), .exc_out(exc_out)
    );

    // Behavioural reference model
    int m_cnt = 0, m_rem = 0, m_ph = 0;
    bit m_fast = 0, m_phfree = 0, m_pfree = 0, m_act = 0;
    bit [3:0] m_en = 0, m_inv = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_rem = 0; m_ph = 0; m_fast = 0; m_phfree = 0;
            m_pfree = 0; m_act = 0; m_en = 0; m_inv = 0;
        end else begin
            int len;
            len = m_fast ? 8 : 16;
            if (!m_act) begin
                if (start && (m_pfree ? (m_en != 0) : (m_cnt != 0))) begin
                    m_act = 1; m_rem = m_cnt; m_ph = 0;
                end else if (m_phfree && adc_en) begin
                    m_ph = (m_ph >= len - 1) ? 0 : m_ph + 1;
                end else begin
                    m_ph = 0;
                end
            end else if (m_pfree && m_en == 0) begin
                m_act = 0; m_ph = 0;
            end else if (m_ph >= len - 1) begin
                m_ph = 0;
                if (!m_pfree) begin
                    if (m_rem <= 1) m_act = 0;
                    else m_rem = m_rem - 1;
                end
            end else begin
                m_ph = m_ph + 1;
            end
            if (cfg_we) begin
                m_cnt = int'(cfg_wdata[11:0]); m_fast = cfg_wdata[12];
                m_phfree = cfg_wdata[13]; m_pfree = cfg_wdata[14];
            end
            if (ctl_we) begin
                m_inv = ctl_wdata[3:0]; m_en = ctl_wdata[7:4];
            end
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            bit [3:0] e;
            int half;
            half = m_fast ? 4 : 8;
            for (int i = 0; i < 4; i++)
                e[i] = (m_en[i] && m_act && (m_ph < half)) ^ m_inv[i];
            check("R3 busy", int'(busy), int'(m_act));
            check("R7 phase", int'(phase), m_ph);
            check("R8 exc_out", int'(exc_out), int'(e));
            check("R2 readback", int'({ctl_rdata, cfg_rdata}),
                  int'({m_act, m_en, m_inv, m_pfree, m_phfree, m_fast, m_cnt[11:0]}));
        end
    end

    task automatic wr_cfg(input bit pf, input bit phf, input bit fst, input int n);
        @(negedge clk); #1;
        cfg_we = 1; cfg_wdata = {pf, phf, fst, 12'(n)};
        @(negedge clk); #1;
        cfg_we = 0;
    endtask

    task automatic wr_ctl(input bit [3:0] en, input bit [3:0] inv);
        @(negedge clk); #1;
        ctl_we = 1; ctl_wdata = {en, inv};
        @(negedge clk); #1;
        ctl_we = 0;
    endtask

    task automatic pulse_start();
        @(negedge clk); #1;
        start = 1;
        @(negedge clk); #1;
        start = 0;
    endtask

    // Start, then count busy clocks and high clocks on output 0; a restart at clock `again` if >0
    task automatic run(output int bcyc, output int hcyc, input int again);
        int seen;
        bcyc = 0; hcyc = 0; seen = 0;
        @(negedge clk); #1; start = 1;
        @(negedge clk);
        if (busy) begin bcyc++; if (exc_out[0]) hcyc++; seen = 1; end
        #1; start = 0;
        for (int k = 0; k < 3000; k++) begin
            @(negedge clk);
            if (busy) begin bcyc++; if (exc_out[0]) hcyc++; seen = 1; end
            else if (seen) break;
            if (again > 0 && bcyc == again) begin #1; start = 1; end
            else begin #1; start = 0; end
        end
        start = 0;
    endtask

    initial begin
        #2000000;
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int b, h;
        repeat (3) @(negedge clk);
        check("R1 reset busy", int'(busy), 0);
        check("R1 reset readback", int'({ctl_rdata, cfg_rdata}), 0);
        check("R1 reset outputs", int'(exc_out), 0);
        check("R1 reset phase", int'(phase), 0);
        #1 rst_n = 1;

        wr_ctl(4'hF, 4'h0);
        wr_cfg(0, 0, 0, 3);
        check("R2 cfg readback", int'(cfg_rdata), 15'h0003);
        check("R2 ctl readback", int'(ctl_rdata), 9'h0F0);
        run(b, h, 0);
        check("R3 busy clocks N=3 normal", b, 48);
        check("R4 high clocks normal", h, 24);
        check("R10 phase zero at stop", int'(phase), 0);

        wr_cfg(0, 0, 1, 2);
        run(b, h, 0);
        check("R4 busy clocks N=2 double", b, 16);
        check("R4 high clocks double", h, 8);

        wr_cfg(0, 0, 0, 0);
        pulse_start();
        repeat (20) @(negedge clk);
        check("R5 count zero stays idle", int'(busy), 0);

        wr_cfg(0, 0, 0, 2);
        run(b, h, 10);
        check("R9 restart ignored", b, 32);

        wr_ctl(4'b0110, 4'b1010);
        wr_cfg(0, 0, 0, 1);
        @(negedge clk);
        check("R8 idle levels", int'(exc_out), 4'b1010);
        run(b, h, 0);
        check("R8 single pulse length", b, 16);

        wr_ctl(4'b0000, 4'b0000);
        wr_cfg(1, 0, 0, 1);
        pulse_start();
        repeat (5) @(negedge clk);
        check("R6 no enables no start", int'(busy), 0);
        wr_ctl(4'b1000, 4'b0000);
        pulse_start();
        repeat (100) @(negedge clk);
        check("R6 free-run still busy", int'(busy), 1);
        wr_ctl(4'b0000, 4'b0000);
        @(negedge clk);
        check("R6 stop after enables cleared", int'(busy), 0);
        check("R10 phase zero after stop", int'(phase), 0);

        wr_cfg(0, 1, 0, 0);
        #1 adc_en = 1;
        repeat (5) @(negedge clk);
        check("R7 idle phase free-runs", int'(phase != 0), 1);
        #1 adc_en = 0;
        @(negedge clk);
        check("R7 phase cleared without adc_en", int'(phase), 0);

        wr_ctl(4'b0001, 4'b0000);
        wr_cfg(0, 0, 0, 2);
        #1 adc_en = 1;
        run(b, h, 0);
        check("R3 count with adc_en", b, 32);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule